// File: doc/BRIEF.md
# Clock Fan-out Buffer Power-Mode Controller

This block sits beside the analog PLL of a zero-delay differential clock fan-out buffer and decides, on a free-running reference clock, whether the PLL runs, whether the ten clock output pairs and the feedback pair are driven, and whether the PLL is bypassed. It watches three things: an active-low power-down request, a strap that is high when the analog supply is grounded for test, and the incoming clock itself. It produces a PLL enable, a shared output enable, a bypass select and a 3-bit status code.

The incoming clock is measured by letting it run a small divider counter in its own domain. The top bit of that counter is synchronized into the reference domain, and its transitions are counted over a fixed window of `WIN_LEN` reference cycles, so count = rising edges / 2^(DIV_W-1). Two thresholds form a hysteresis band. A window is graded slow when its count is below `LO_THR`, fast when it is at or above `HI_THR`, and neutral in between. The "frequency good" flag changes only after two consecutive windows agree. The defaults (500-cycle window, divide by 4, thresholds 18 and 22) place the boundary near 20 MHz with a 125 MHz reference. A lock timer of `LOCK_CYC` reference cycles (12500 by default, 100 µs) keeps the outputs off after every PLL start.

The power-down request overrides everything except test bypass. A low-frequency condition puts the block to sleep on its own, and recovery restarts the PLL with no outside help.

Top module: `clkbuf_pm_ctrl`

## Requirements
- R1: An asynchronous reset (rst_n low) puts the block in OFF (state_code 0) with pll_en, out_en and bypass_sel low. The block stays in OFF after reset until the first measurement window of WIN_LEN reference cycles has ended.
- R2: state_code encodes OFF=0, SLEEP=1, LOCK=2, RUN=3, BYPASS=4. pll_en is high only in LOCK and RUN. out_en is high only in RUN and BYPASS. bypass_sel is high only in BYPASS.
- R3: With test_strap low, pd_n low forces OFF in the state seen after the third rising reference edge following the change (two synchronizer flops plus the state register), from any state. Releasing the strap while pd_n is low also leads to OFF.
- R4: With pd_n high and the strap low, two consecutive windows with count below LO_THR (a stopped clock included) lead to SLEEP, with the PLL off and the outputs off.
- R5: Two consecutive windows with count at or above HI_THR set the frequency-good condition. From OFF or SLEEP with pd_n high, the block then goes to LOCK and on to RUN with no outside action.
- R6: LOCK lasts exactly LOCK_CYC reference cycles with pll_en high and out_en low. RUN is entered only from LOCK.
- R7: Windows with count in [LO_THR, HI_THR) change nothing: RUN stays RUN and SLEEP stays SLEEP.
- R8: A single slow window, or a slow window next to a neutral one, does not take the block out of RUN.
- R9: test_strap high gives BYPASS three rising reference edges later, from any state, whatever pd_n and the input frequency are.
- R10: Releasing test_strap with pd_n high and the frequency good gives LOCK three edges later, then RUN after LOCK_CYC more cycles. The block never goes straight from BYPASS to RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_clk | input | 1 | Monitored input clock of the buffer |
| pd_n | input | 1 | Power-down request, low = power down (asynchronous) |
| test_strap | input | 1 | High when the analog supply is grounded (test bypass, asynchronous) |
| pll_en | output | 1 | PLL run enable |
| out_en | output | 1 | Enable for all clock and feedback output pairs (low = high impedance) |
| bypass_sel | output | 1 | Selects the input clock directly instead of the PLL |
| state_code | output | 3 | Current mode code |

## Verification
The control inputs reach the state register three rising reference edges after they change. The bench drives them just after a falling edge and samples at the falling edge that follows the third rising edge. It also samples one cycle earlier, to show that nothing moved too soon. The lock-wait exit is due exactly LOCK_CYC cycles after LOCK is entered, and the bench checks both the last LOCK cycle and the first RUN cycle. A frequency change is resolved only at the end of a window, which the bench does not line up with. For these changes it waits long enough to cover one partial window and two full ones plus the lock time before it checks the settled mode. The glitch case runs a per-cycle watch that records any departure from RUN.

// File: rtl/clkbuf_pm_pkg.sv
package clkbuf_pm_pkg;

  typedef enum logic [2:0] {
    PM_OFF    = 3'd0,
    PM_SLEEP  = 3'd1,
    PM_LOCK   = 3'd2,
    PM_RUN    = 3'd3,
    PM_BYPASS = 3'd4
  } pm_state_e;

  typedef enum logic [1:0] {
    FV_SLOW = 2'd0,
    FV_BAND = 2'd1,
    FV_FAST = 2'd2
  } fverdict_e;

  // bits needed to hold values 0..max_val
  function automatic int unsigned cnt_bits(int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

  // grade one window count against the hysteresis band
  function automatic fverdict_e grade(int unsigned cnt, int unsigned lo, int unsigned hi);
    if (cnt < lo)  return FV_SLOW;
    if (cnt >= hi) return FV_FAST;
    return FV_BAND;
  endfunction

  function automatic logic pll_on(pm_state_e s);
    return (s == PM_LOCK) || (s == PM_RUN);
  endfunction

  function automatic logic drive_on(pm_state_e s);
    return (s == PM_RUN) || (s == PM_BYPASS);
  endfunction

endpackage

// File: rtl/pm_sync2.sv
module pm_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/pm_freq_meter.sv
module pm_freq_meter
  import clkbuf_pm_pkg::*;
#(
  parameter int unsigned WIN_LEN = 500,
  parameter int unsigned DIV_W   = 3,
  parameter int unsigned LO_THR  = 18,
  parameter int unsigned HI_THR  = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon_clk,
  output logic freq_ok,
  output logic win_done
);
  localparam int unsigned CW = cnt_bits(WIN_LEN);

  // divider in the monitored domain; its top bit crosses over
  logic [DIV_W-1:0] div_q;
  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  logic tog_s, tog_d;
  pm_sync2 #(.W(1)) u_tog_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (div_q[DIV_W-1]),
    .q     (tog_s)
  );

  logic [CW-1:0] win_cnt, edge_cnt, cnt_now;
  logic          edge_hit, win_end;
  fverdict_e     cur_v, prev_v;

  assign edge_hit = tog_s ^ tog_d;
  assign win_end  = (win_cnt == CW'(WIN_LEN - 1));
  assign cnt_now  = edge_cnt + CW'(edge_hit);
  assign cur_v    = grade(32'(cnt_now), LO_THR, HI_THR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_d    <= 1'b0;
      win_cnt  <= '0;
      edge_cnt <= '0;
      prev_v   <= FV_BAND;
      freq_ok  <= 1'b0;
      win_done <= 1'b0;
    end else begin
      tog_d    <= tog_s;
      win_done <= win_end;
      if (win_end) begin
        win_cnt  <= '0;
        edge_cnt <= '0;
        prev_v   <= cur_v;
        if (cur_v == FV_FAST && prev_v == FV_FAST)      freq_ok <= 1'b1;
        else if (cur_v == FV_SLOW && prev_v == FV_SLOW) freq_ok <= 1'b0;
      end else begin
        win_cnt  <= win_cnt + 1'b1;
        edge_cnt <= cnt_now;
      end
    end
  end

  AST_OK_MOVES_AT_WINDOW_END: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_ok != $past(freq_ok)) |-> $past(win_end)); // R8

  AST_OK_NEEDS_PRIOR_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(freq_ok) |-> $past(prev_v == FV_FAST)); // R5

endmodule

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm
  import clkbuf_pm_pkg::*;
#(
  parameter int unsigned LOCK_CYC = 12500
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pd_s,
  input  logic      byp_s,
  input  logic      freq_ok,
  input  logic      win_done,
  output pm_state_e state
);
  localparam int unsigned LW = cnt_bits(LOCK_CYC);

  pm_state_e     nxt;
  logic [LW-1:0] lock_cnt;
  logic          lock_done;
  logic          meas_seen;

  assign lock_done = (state == PM_LOCK) && (lock_cnt == LW'(LOCK_CYC - 1));

  always_comb begin
    nxt = state;
    if (byp_s)                   nxt = PM_BYPASS;
    else if (!pd_s || !meas_seen) nxt = PM_OFF;
    else if (!freq_ok)           nxt = PM_SLEEP;
    else begin
      unique case (state)
        PM_RUN:  nxt = PM_RUN;
        PM_LOCK: nxt = lock_done ? PM_RUN : PM_LOCK;
        default: nxt = PM_LOCK;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= PM_OFF;
      lock_cnt  <= '0;
      meas_seen <= 1'b0;
    end else begin
      state     <= nxt;
      lock_cnt  <= (state == PM_LOCK && nxt == PM_LOCK) ? lock_cnt + 1'b1 : '0;
      if (win_done) meas_seen <= 1'b1;
    end
  end

  AST_PD_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_s && !byp_s) |=> (state == PM_OFF)); // R3

  AST_STRAP_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    byp_s |=> (state == PM_BYPASS)); // R9

  AST_RUN_ONLY_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_RUN && $past(state) != PM_RUN) |-> ($past(state) == PM_LOCK && $past(lock_done))); // R6

  AST_SLEEP_ONLY_LOWFREQ: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_SLEEP) |-> !$past(freq_ok)); // R4

endmodule

// File: rtl/clkbuf_pm_ctrl.sv
module clkbuf_pm_ctrl
  import clkbuf_pm_pkg::*;
#(
  parameter int unsigned WIN_LEN  = 500,
  parameter int unsigned DIV_W    = 3,
  parameter int unsigned LO_THR   = 18,
  parameter int unsigned HI_THR   = 22,
  parameter int unsigned LOCK_CYC = 12500
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic       mon_clk,
  input  logic       pd_n,
  input  logic       test_strap,
  output logic       pll_en,
  output logic       out_en,
  output logic       bypass_sel,
  output logic [2:0] state_code
);
  logic [1:0] ctl_s;
  logic       freq_ok, win_done;
  pm_state_e  state;

  pm_sync2 #(.W(2)) u_ctl_sync (
    .clk   (clk_ref),
    .rst_n (rst_n),
    .d     ({test_strap, pd_n}),
    .q     (ctl_s)
  );

  pm_freq_meter #(
    .WIN_LEN (WIN_LEN),
    .DIV_W   (DIV_W),
    .LO_THR  (LO_THR),
    .HI_THR  (HI_THR)
  ) u_meter (
    .clk      (clk_ref),
    .rst_n    (rst_n),
    .mon_clk  (mon_clk),
    .freq_ok  (freq_ok),
    .win_done (win_done)
  );

  pm_mode_fsm #(
    .LOCK_CYC (LOCK_CYC)
  ) u_fsm (
    .clk      (clk_ref),
    .rst_n    (rst_n),
    .pd_s     (ctl_s[0]),
    .byp_s    (ctl_s[1]),
    .freq_ok  (freq_ok),
    .win_done (win_done),
    .state    (state)
  );

  assign pll_en     = pll_on(state);
  assign out_en     = drive_on(state);
  assign bypass_sel = (state == PM_BYPASS);
  assign state_code = state;

endmodule

// File: tb/clkbuf_pm_ctrl_test.sv
`timescale 1ns/1ps
module clkbuf_pm_ctrl_test;
  localparam int LCK = 40;

  logic clk = 0, rst_n = 0, mon_clk = 0, pd_n = 1, test_strap = 0;
  logic pll_en, out_en, bypass_sel;
  logic [2:0] state_code;
  int mon_half = 5;
  logic mon_on = 1;

  clkbuf_pm_ctrl #(
    .WIN_LEN(100), .DIV_W(2), .LO_THR(12), .HI_THR(20), .LOCK_CYC(LCK)
  ) uut (
    .clk_ref(clk), .rst_n(rst_n), .mon_clk(mon_clk), .pd_n(pd_n),
    .test_strap(test_strap), .pll_en(pll_en), .out_en(out_en),
    .bypass_sel(bypass_sel), .state_code(state_code)
  );

  always #4 clk = ~clk;
  always begin
    if (mon_on) begin #(mon_half); mon_clk = ~mon_clk; end
    else #1;
  end

  typedef struct { int due; logic [2:0] code; string req; } exp_t;
  exp_t q[$];
  int cyc = 0, checks = 0, fails = 0, glitch_cnt = 0;
  logic watch_run = 0, done = 0;

  // mode codes per R2
  localparam logic [2:0] C_OFF = 3'd0, C_SLEEP = 3'd1, C_LOCK = 3'd2, C_RUN = 3'd3, C_BYP = 3'd4;

  // monitor: pops due items and compares all outputs against the R2 decode
  always @(negedge clk) begin
    cyc++;
    if (watch_run && state_code != C_RUN) glitch_cnt++;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due <= cyc) begin
        logic ep, eo, eb;
        ep = (q[i].code == C_LOCK) || (q[i].code == C_RUN);
        eo = (q[i].code == C_RUN) || (q[i].code == C_BYP);
        eb = (q[i].code == C_BYP);
        checks++;
        if (state_code !== q[i].code || pll_en !== ep || out_en !== eo || bypass_sel !== eb) begin
          fails++;
          $display("FAIL %s (R2 decode) cyc=%0d: code=%0d pll=%b oe=%b byp=%b expected code=%0d pll=%b oe=%b byp=%b",
                   q[i].req, cyc, state_code, pll_en, out_en, bypass_sel, q[i].code, ep, eo, eb);
        end
        q.delete(i);
      end
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic expect_at(int k, logic [2:0] c, string r);
    exp_t e;
    e.due = cyc + k; e.code = c; e.req = r;
    q.push_back(e);
  endtask

  initial begin
    idle(3);
    expect_at(1, C_OFF, "R1 in reset");
    idle(3);
    step(); rst_n = 1;
    expect_at(5, C_OFF, "R1 after reset");
    expect_at(60, C_OFF, "R1 before first window");
    expect_at(450, C_RUN, "R5 start-up to RUN");
    idle(460);

    step(); pd_n = 0;
    expect_at(2, C_RUN, "R3 not yet");
    expect_at(3, C_OFF, "R3 power-down");
    idle(10);
    step(); pd_n = 1;
    expect_at(3, C_LOCK, "R6 lock entry");
    expect_at(2 + LCK, C_LOCK, "R6 last lock cycle");
    expect_at(3 + LCK, C_RUN, "R6 run after lock");
    idle(LCK + 10);

    step(); mon_half = 15;
    idle(450); expect_at(1, C_RUN, "R7 band keeps RUN"); idle(3);
    step(); mon_half = 50;
    idle(450); expect_at(1, C_SLEEP, "R4 low frequency"); idle(3);
    step(); mon_half = 15;
    idle(450); expect_at(1, C_SLEEP, "R7 band keeps SLEEP"); idle(3);
    step(); mon_half = 5;
    idle(450); expect_at(1, C_RUN, "R5 recovery"); idle(3);

    // R8: stop the input for 120 cycles, no two slow windows can result
    step(); watch_run = 1; mon_on = 0;
    idle(120);
    step(); mon_on = 1;
    idle(400);
    step(); watch_run = 0;
    checks++;
    if (glitch_cnt != 0) begin
      fails++;
      $display("FAIL R8 glitch: cycles out of RUN=%0d expected=0", glitch_cnt);
    end
    expect_at(1, C_RUN, "R8 still RUN"); idle(3);

    step(); test_strap = 1;
    expect_at(2, C_RUN, "R9 not yet");
    expect_at(3, C_BYP, "R9 bypass");
    idle(5);
    step(); pd_n = 0; mon_half = 50;
    expect_at(3, C_BYP, "R9 ignores power-down");
    idle(350); expect_at(1, C_BYP, "R9 ignores low frequency"); idle(3);
    step(); mon_half = 5; pd_n = 1;
    idle(450);
    step(); test_strap = 0;
    expect_at(3, C_LOCK, "R10 lock after bypass");
    expect_at(3 + LCK, C_RUN, "R10 run after lock");
    idle(LCK + 10);

    step(); test_strap = 1; idle(5);
    step(); pd_n = 0; idle(5);
    step(); test_strap = 0;
    expect_at(3, C_OFF, "R3 strap release into power-down");
    idle(5);
    step(); pd_n = 1; idle(LCK + 10);

    step(); mon_on = 0;
    idle(450); expect_at(1, C_SLEEP, "R4 stopped clock"); idle(3);
    step(); pd_n = 0;
    expect_at(3, C_OFF, "R3 overrides sleep"); idle(10);
    step(); pd_n = 1;
    expect_at(3, C_SLEEP, "R4 back to sleep"); idle(5);
    step(); mon_on = 1;
    idle(450); expect_at(1, C_RUN, "R5 restart from stopped"); idle(3);

    step(); rst_n = 0;
    expect_at(1, C_OFF, "R1 async reset"); idle(3);
    step(); rst_n = 1;
    expect_at(50, C_OFF, "R1 wait first window");
    idle(60);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog: run state=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule